// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block chooses which of two oscillators drives the chip's system clock: an on-die main oscillator or a clock brought in from a pin. A single enable bit written by firmware requests the external source. The handover closes the gate of the old source on one of its own falling edges. It opens the gate of the new source on one of the new source's falling edges, and only once the old gate is known to be shut. The system clock therefore never carries a shortened high or low phase. Out of reset the block always runs from the internal oscillator, and the external source can only be reached by a later firmware write.

The block also derives the CPU clock from the system clock through a power-of-two divider. The divider setting decides when a new select value is accepted. With a ratio of 1 the request is taken on any system-clock rising edge. With a larger ratio it is taken only on the system-clock rising edge that also raises the CPU clock, so a change of source always starts at a CPU clock boundary. An oscillator-disable bit lets firmware stop the internal oscillator to save power. The block honours that bit only while the external source is really the active one.

Top module: `sysclk_src_switch`

## Requirements
- R1: While reset is asserted and after it is released, the internal oscillator drives `sys_clk`, `ext_active` is 0 and `osc_en` is 1.
- R2: After `ext_sel` rises and is accepted, `sys_clk` follows `clk_ext`. `ext_active` becomes 1 on the first `sys_clk` rising edge produced by the external source, and not earlier.
- R3: After `ext_sel` falls and is accepted, `sys_clk` follows `clk_int` again. `ext_active` returns to 0 on the first `sys_clk` rising edge produced by the internal source.
- R4: The two source gates are never open together. No high or low phase of `sys_clk` is shorter than the shorter half-period of the two sources, in either switching direction.
- R5: `cpu_div` picks the CPU clock ratio. The codes 0 to 7 give 1, 2, 4, 8, 16, 32, 128 and 256. With code 0, `cpu_clk` equals `sys_clk`.
- R6: With `cpu_div` nonzero, `ext_sel` is sampled only on the `sys_clk` rising edge where `cpu_clk` rises. A level change that is reverted before that edge has no effect on the source. With code 0 it is sampled on every `sys_clk` rising edge.
- R7: `osc_en` is 0 only while `osc_off` is 1 and `ext_active` is 1. Setting `osc_off` while the internal source is active leaves `osc_en` at 1.
- R8: The external input works at any rate from 1 MHz to 12 MHz, with `sys_clk` taking that input's period after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal main oscillator clock |
| clk_ext | input | 1 | External clock from the input pin |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_sel | input | 1 | Firmware request: 1 selects the external source |
| osc_off | input | 1 | Firmware request to stop the internal oscillator |
| cpu_div | input | 3 | CPU clock ratio code |
| sys_clk | output | 1 | Selected system clock |
| cpu_clk | output | 1 | Divided CPU clock |
| osc_en | output | 1 | Enable for the internal oscillator |
| ext_active | output | 1 | 1 while the external source is actually driving `sys_clk` |

## Verification
The bench times every edge of `sys_clk` through switches in both directions and at both ends of the external frequency range. A mux that swaps sources without handshaking would show a sliver pulse there. A short select pulse is placed inside a long CPU period. A design that samples the request on any system edge would switch when it should not. The bench also measures all eight CPU ratios, since a wrong bit pick shows up as a halved or doubled period. It sets the oscillator-disable bit before and after the handover, because a design that ignores the active source would stop the oscillator it is still running on.

// File: rtl/sysclk_src_switch.sv
module sysclk_src_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3,
  parameter int CNT_W       = 8
) (
  input  logic             clk_int,
  input  logic             clk_ext,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             osc_off,
  input  logic [DIV_W-1:0] cpu_div,
  output logic             sys_clk,
  output logic             cpu_clk,
  output logic             osc_en,
  output logic             ext_active
);
  localparam int SEL_W = $clog2(CNT_W);

  logic                   req_q;
  logic [SYNC_STAGES-1:0] int_sync;
  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   int_gate;
  logic                   ext_gate;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       cnt_nxt;
  logic [SEL_W-1:0]       bitsel;
  logic                   cpu_rise;

  assign int_gate = int_sync[SYNC_STAGES-1];
  assign ext_gate = ext_sync[SYNC_STAGES-1];

  always_ff @(negedge clk_int or negedge rst_n)
    if (!rst_n) int_sync <= '1;
    else        int_sync <= {int_sync[SYNC_STAGES-2:0], ~req_q & ~ext_gate};

  always_ff @(negedge clk_ext or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[SYNC_STAGES-2:0], req_q & ~int_gate};

  assign sys_clk = (clk_int & int_gate) | (clk_ext & ext_gate);

  assign bitsel   = (cpu_div > DIV_W'(5)) ? SEL_W'(cpu_div) : SEL_W'(cpu_div - DIV_W'(1));
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign cpu_rise = cnt_nxt[bitsel] & ~cnt[bitsel];

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;

  assign cpu_clk = (cpu_div == '0) ? sys_clk : cnt[bitsel];

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n)                             req_q <= 1'b0;
    else if ((cpu_div == '0) || cpu_rise)   req_q <= ext_sel;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n)        ext_active <= 1'b0;
    else if (ext_gate) ext_active <= 1'b1;
    else if (int_gate) ext_active <= 1'b0;

  assign osc_en = ~(osc_off & ext_active);

  a_r4_excl_int: assert property (@(negedge clk_int) disable iff (!rst_n)
    !(int_gate && ext_gate));
  a_r4_excl_ext: assert property (@(negedge clk_ext) disable iff (!rst_n)
    !(int_gate && ext_gate));
  a_r2_status_set: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ext_gate |=> ext_active);
  a_r3_status_clr: assert property (@(posedge sys_clk) disable iff (!rst_n)
    int_gate |=> !ext_active);
  a_r6_req_hold: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ((cpu_div != '0) && !cpu_rise) |=> $stable(req_q));
  a_r7_osc_kept: assert property (@(negedge clk_int) disable iff (!rst_n)
    int_gate |-> osc_en);
endmodule

// File: tb/sysclk_src_switch_bench.sv
`timescale 1ns/1ps
module sysclk_src_switch_bench;
  logic       clk_int = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_sel = 1'b0;
  logic       osc_off = 1'b0;
  logic [2:0] cpu_div = 3'd0;
  logic       sys_clk, cpu_clk, osc_en, ext_active;

  int checks = 0;
  int failures = 0;
  int ext_half = 42;
  bit armed = 1'b0;
  bit done = 1'b0;
  realtime last_edge = 0.0;
  realtime min_phase = 1.0e9;

  sysclk_src_switch u_sysclk_src_switch (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .ext_sel(ext_sel),
    .osc_off(osc_off), .cpu_div(cpu_div), .sys_clk(sys_clk), .cpu_clk(cpu_clk),
    .osc_en(osc_en), .ext_active(ext_active));

  initial forever begin
    if (osc_en) begin clk_int = 1'b1; #10; clk_int = 1'b0; #10; end
    else #10;
  end

  initial forever #(ext_half) clk_ext = ~clk_ext;

  always @(sys_clk) begin
    if (armed) begin
      if ($realtime - last_edge < min_phase) min_phase = $realtime - last_edge;
    end
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio(input int code);
    case (code)
      0: return 1;   1: return 2;   2: return 4;   3: return 8;
      4: return 16;  5: return 32;  6: return 128; default: return 256;
    endcase
  endfunction

  task automatic sys_period(output int p);
    realtime t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = int'($realtime - t0);
  endtask

  task automatic cpu_period(output int p);
    realtime t0;
    @(posedge cpu_clk); t0 = $realtime;
    @(posedge cpu_clk); p = int'($realtime - t0);
  endtask

  task automatic wait_active(input logic v, input string req);
    int n = 0;
    while (ext_active !== v && n < 50000) begin #7; n++; end
    chk(ext_active === v, req, "ext_active after handover", int'(ext_active), int'(v));
  endtask

  task automatic t_reset();
    int p;
    #3;
    chk(ext_active === 1'b0, "R1", "ext_active in reset", int'(ext_active), 0);
    chk(osc_en === 1'b1, "R1", "osc_en in reset", int'(osc_en), 1);
    #52 rst_n = 1'b1;
    @(posedge sys_clk); #1 armed = 1'b1;
    sys_period(p);
    chk(p == 20, "R1", "sys_clk period after reset", p, 20);
    chk(ext_active === 1'b0, "R1", "ext_active after reset", int'(ext_active), 0);
  endtask

  task automatic t_dividers();
    int p;
    for (int c = 0; c < 8; c++) begin
      @(negedge sys_clk); cpu_div = 3'(c);
      @(posedge cpu_clk); @(posedge cpu_clk);
      cpu_period(p);
      chk(p == 20 * ratio(c), "R5", $sformatf("cpu_clk period code %0d", c), p, 20 * ratio(c));
    end
  endtask

  task automatic t_short_request();
    int p;
    @(negedge sys_clk); cpu_div = 3'd7;
    @(posedge cpu_clk); #100 ext_sel = 1'b1;
    #1000 ext_sel = 1'b0;
    #6000;
    chk(ext_active === 1'b0, "R6", "short request between cpu edges", int'(ext_active), 0);
    sys_period(p);
    chk(p == 20, "R6", "source kept after short request", p, 20);
  endtask

  task automatic t_to_ext_fast();
    int p;
    ext_half = 42;
    @(posedge cpu_clk); #100 ext_sel = 1'b1;
    #2000;
    chk(ext_active === 1'b0, "R6", "request waits for cpu edge", int'(ext_active), 0);
    wait_active(1'b1, "R2");
    sys_period(p);
    chk(p == 84, "R2", "sys_clk period on external 12 MHz", p, 84);
    @(negedge sys_clk); cpu_div = 3'd0;
    #300 ext_sel = 1'b0;
    wait_active(1'b0, "R3");
    sys_period(p);
    chk(p == 20, "R3", "sys_clk period back on internal", p, 20);
  endtask

  task automatic t_slow_ext_osc();
    int p;
    ext_half = 500;
    #2000;
    @(negedge sys_clk); cpu_div = 3'd1;
    osc_off = 1'b1;
    #5;
    chk(osc_en === 1'b1, "R7", "osc_en kept while internal active", int'(osc_en), 1);
    ext_sel = 1'b1;
    wait_active(1'b1, "R2");
    #50;
    chk(osc_en === 1'b0, "R7", "osc_en dropped on external", int'(osc_en), 0);
    sys_period(p);
    chk(p == 1000, "R8", "sys_clk period on external 1 MHz", p, 1000);
    osc_off = 1'b0;
    #5;
    chk(osc_en === 1'b1, "R7", "osc_en back after clearing disable", int'(osc_en), 1);
    #1000 ext_sel = 1'b0;
    wait_active(1'b0, "R3");
    sys_period(p);
    chk(p == 20, "R3", "sys_clk period after return from 1 MHz", p, 20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_dividers();
    t_short_request();
    t_to_ext_fast();
    t_slow_ext_osc();
    chk(min_phase >= 9.999, "R4", "shortest sys_clk phase (ps)",
        int'(min_phase * 1000.0), 10000);
    finish_run();
  end
endmodule